// File: doc/BRIEF.md
# Port Control Decoder with Mailbox

This block is the control logic for one side of a buffer that moves words in both directions through two FIFOs. On every rising port clock it reads four control inputs: an active-low chip select, a direction select, an enable and a mailbox select. From them it produces single-cycle strobes that write the outbound FIFO, read the inbound FIFO, load the outbound mail register and consume the inbound mail word. The FIFO storage and the flag synchronizers sit outside the block. The block receives their input-ready and output-ready flags as inputs.

The data bus is split into an input path and an output path with an output-enable. The output path carries either the inbound FIFO's output register or the inbound mail register, and the mailbox select chooses between them. The block owns the outbound mail register and that register's active-low full flag. The opposite port consumes the outbound mail and signals this with a release pulse. Parameter `WR_LEVEL` sets which level of the direction select means "write". The two sides of a buffer use opposite settings.

Top module: `pctl_port`

## Requirements
- R1: `dout_oe` is 1 exactly when `cs_n` is 0 and `rw_sel` differs from `WR_LEVEL` (default 0: `rw_sel`=1 is the read level). Otherwise it is 0. This output is combinational.
- R2: When `cs_n`=0, `rw_sel`=`WR_LEVEL`, `en`=1, `mb_sel`=0 and `in_rdy`=1 at a rising edge, `fifo_wr` is 1 for the following cycle only, and `fifo_wdata` holds the `bus_in` word sampled at that edge.
- R3: When `cs_n`=0, `rw_sel`≠`WR_LEVEL`, `en`=1, `mb_sel`=0 and `out_rdy`=1 at a rising edge, `fifo_rd` is 1 for the following cycle only.
- R4: While `dout_oe` is 1, `dout` equals `fifo_q` when `mb_sel`=0 and equals `mail_in_q` when `mb_sel`=1, whatever the value of `en`.
- R5: When the write conditions of R2 hold except that `mb_sel`=1 and `mail_out_full_n` is 1, the edge loads `bus_in` into `mail_out_q`, drives `mail_out_full_n` to 0 and gives a one-cycle `mbx_wr` pulse. No `fifo_wr` pulse follows.
- R6: A mail write attempted while `mail_out_full_n` is 0 is ignored. `mail_out_q` keeps its value and no `mbx_wr` pulse follows.
- R7: When `cs_n`=0, `rw_sel`≠`WR_LEVEL`, `en`=1 and `mb_sel`=1 at a rising edge, `mbx_rd` is 1 for the following cycle only. The opposite port uses this pulse to release its full flag. No `fifo_rd` follows.
- R8: When `peer_mbx_rd`=1 at an edge with no mail write accepted at that edge, `mail_out_full_n` becomes 1. A mail write arriving at the same edge as the release, while the register is full, is still ignored.
- R9: When `en`=0 at an edge, no strobe follows, whatever the values of `cs_n`, `rw_sel`, `mb_sel` and the ready flags.
- R10: While `rst`=1 at an edge, all strobes go to 0, `mail_out_full_n` goes to 1 and `mail_out_q` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rw_sel | input | 1 | Direction select; level `WR_LEVEL` means write |
| en | input | 1 | Transfer enable |
| mb_sel | input | 1 | Routes the transfer to the mail registers |
| in_rdy | input | 1 | Outbound FIFO can accept a word |
| out_rdy | input | 1 | Inbound FIFO output register holds a word |
| bus_in | input | DATA_W | Word presented on the bus |
| fifo_q | input | DATA_W | Inbound FIFO output register |
| mail_in_q | input | DATA_W | Inbound mail register (owned by the opposite port) |
| peer_mbx_rd | input | 1 | Opposite port consumed the outbound mail |
| dout | output | DATA_W | Word to drive onto the bus |
| dout_oe | output | 1 | Bus drive enable |
| fifo_wr | output | 1 | Outbound FIFO write strobe |
| fifo_wdata | output | DATA_W | Word for the outbound FIFO |
| fifo_rd | output | 1 | Inbound FIFO read strobe |
| mbx_wr | output | 1 | Outbound mail load pulse |
| mbx_rd | output | 1 | Inbound mail consumed pulse |
| mail_out_q | output | DATA_W | Outbound mail register |
| mail_out_full_n | output | 1 | Outbound mail full flag, active low |

## Verification
The local write attempt and the release from the opposite port can act on the outbound mail register at the same edge. A write that arrives while the register is full must be ignored, even though the release empties the flag at that edge. A write that arrives while the register is empty must win and leave the flag full. The bench provokes both orderings with directed sequences and with random `peer_mbx_rd` pulses mixed into random mail writes. A reference model that decides acceptance from the flag's value before the edge judges each result.

// File: rtl/pctl_pkg.sv
package pctl_pkg;

    typedef enum logic [1:0] {
        DIR_IDLE  = 2'd0,
        DIR_WRITE = 2'd1,
        DIR_READ  = 2'd2
    } port_dir_t;

    typedef struct packed {
        logic fifo_wr;
        logic fifo_rd;
        logic mbx_wr;
        logic mbx_rd;
    } port_op_t;

    localparam port_op_t OP_NONE = '{fifo_wr: 1'b0, fifo_rd: 1'b0, mbx_wr: 1'b0, mbx_rd: 1'b0};

    function automatic port_dir_t port_dir(input logic cs_n, input logic rw, input logic wr_level);
        if (cs_n)
            return DIR_IDLE;
        return (rw == wr_level) ? DIR_WRITE : DIR_READ;
    endfunction

    function automatic port_op_t decode_op(
        input port_dir_t dir,
        input logic      en,
        input logic      mb,
        input logic      in_rdy,
        input logic      out_rdy,
        input logic      mbx_empty
    );
        port_op_t op;
        op = OP_NONE;
        if (en) begin
            unique case (dir)
                DIR_WRITE: begin
                    op.fifo_wr = !mb && in_rdy;
                    op.mbx_wr  = mb && mbx_empty;
                end
                DIR_READ: begin
                    op.fifo_rd = !mb && out_rdy;
                    op.mbx_rd  = mb;
                end
                default: op = OP_NONE;
            endcase
        end
        return op;
    endfunction

endpackage

// File: rtl/pctl_decode.sv
module pctl_decode
    import pctl_pkg::*;
#(
    parameter logic WR_LEVEL = 1'b0
) (
    input  logic     cs_n,
    input  logic     rw_sel,
    input  logic     en,
    input  logic     mb_sel,
    input  logic     in_rdy,
    input  logic     out_rdy,
    input  logic     mbx_empty,
    output port_op_t op,
    output logic     drive
);
    port_dir_t dir;

    always_comb begin
        dir   = port_dir(cs_n, rw_sel, WR_LEVEL);
        op    = decode_op(dir, en, mb_sel, in_rdy, out_rdy, mbx_empty);
        drive = (dir == DIR_READ);
    end
endmodule

// File: rtl/pctl_strobe_reg.sv
module pctl_strobe_reg
    import pctl_pkg::*;
#(
    parameter int unsigned DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  port_op_t          op_d,
    input  logic [DATA_W-1:0] wdata_d,
    output port_op_t          op_q,
    output logic [DATA_W-1:0] wdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= OP_NONE;
            wdata_q <= '0;
        end else begin
            op_q <= op_d;
            if (op_d.fifo_wr)
                wdata_q <= wdata_d;
        end
    end
endmodule

// File: rtl/pctl_mailbox.sv
module pctl_mailbox #(
    parameter int unsigned DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              release_i,
    output logic [DATA_W-1:0] mail_q,
    output logic              full_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mail_q <= '0;
            full_n <= 1'b1;
        end else if (load) begin
            mail_q <= load_data;
            full_n <= 1'b0;
        end else if (release_i) begin
            full_n <= 1'b1;
        end
    end
endmodule

// File: rtl/pctl_port.sv
module pctl_port
    import pctl_pkg::*;
#(
    parameter int unsigned DATA_W   = 36,
    parameter logic        WR_LEVEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rw_sel,
    input  logic              en,
    input  logic              mb_sel,
    input  logic              in_rdy,
    input  logic              out_rdy,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] fifo_q,
    input  logic [DATA_W-1:0] mail_in_q,
    input  logic              peer_mbx_rd,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              fifo_rd,
    output logic              mbx_wr,
    output logic              mbx_rd,
    output logic [DATA_W-1:0] mail_out_q,
    output logic              mail_out_full_n
);
    port_op_t op_now;
    port_op_t op_reg;
    logic     drive;

    pctl_decode #(.WR_LEVEL(WR_LEVEL)) u_dec (
        .cs_n      (cs_n),
        .rw_sel    (rw_sel),
        .en        (en),
        .mb_sel    (mb_sel),
        .in_rdy    (in_rdy),
        .out_rdy   (out_rdy),
        .mbx_empty (mail_out_full_n),
        .op        (op_now),
        .drive     (drive)
    );

    pctl_strobe_reg #(.DATA_W(DATA_W)) u_stb (
        .clk     (clk),
        .rst     (rst),
        .op_d    (op_now),
        .wdata_d (bus_in),
        .op_q    (op_reg),
        .wdata_q (fifo_wdata)
    );

    pctl_mailbox #(.DATA_W(DATA_W)) u_mbx (
        .clk       (clk),
        .rst       (rst),
        .load      (op_now.mbx_wr),
        .load_data (bus_in),
        .release_i (peer_mbx_rd),
        .mail_q    (mail_out_q),
        .full_n    (mail_out_full_n)
    );

    assign dout_oe = drive;
    assign dout    = mb_sel ? mail_in_q : fifo_q;
    assign fifo_wr = op_reg.fifo_wr;
    assign fifo_rd = op_reg.fifo_rd;
    assign mbx_wr  = op_reg.mbx_wr;
    assign mbx_rd  = op_reg.mbx_rd;
endmodule

// File: rtl/pctl_port_chk.sv
module pctl_port_chk #(
    parameter int unsigned DATA_W   = 36,
    parameter logic        WR_LEVEL = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              rw_sel,
    input logic              en,
    input logic              mb_sel,
    input logic              in_rdy,
    input logic              out_rdy,
    input logic [DATA_W-1:0] bus_in,
    input logic              peer_mbx_rd,
    input logic              fifo_wr,
    input logic              fifo_rd,
    input logic              mbx_wr,
    input logic              mbx_rd,
    input logic [DATA_W-1:0] mail_out_q,
    input logic              mail_out_full_n
);
    logic wr_go, rd_go;
    assign wr_go = !cs_n && (rw_sel == WR_LEVEL) && en;
    assign rd_go = !cs_n && (rw_sel != WR_LEVEL) && en;

    a_r2_fifo_write: assert property (@(posedge clk) disable iff (rst)
        (wr_go && !mb_sel && in_rdy) |=> fifo_wr);

    a_r3_fifo_read: assert property (@(posedge clk) disable iff (rst)
        (rd_go && !mb_sel && out_rdy) |=> fifo_rd);

    a_r5_mail_full: assert property (@(posedge clk) disable iff (rst)
        mbx_wr |-> !mail_out_full_n);

    a_r6_full_hold: assert property (@(posedge clk) disable iff (rst)
        (!mail_out_full_n && !rst) |=> $stable(mail_out_q) && !mbx_wr);

    a_r7_mail_read: assert property (@(posedge clk) disable iff (rst)
        (rd_go && mb_sel) |=> (mbx_rd && !fifo_rd));

    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> !(fifo_wr || fifo_rd || mbx_wr || mbx_rd));

    a_r2_one_hot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fifo_wr, fifo_rd, mbx_wr, mbx_rd}));
endmodule

bind pctl_port pctl_port_chk #(.DATA_W(DATA_W), .WR_LEVEL(WR_LEVEL)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cs_n            (cs_n),
    .rw_sel          (rw_sel),
    .en              (en),
    .mb_sel          (mb_sel),
    .in_rdy          (in_rdy),
    .out_rdy         (out_rdy),
    .bus_in          (bus_in),
    .peer_mbx_rd     (peer_mbx_rd),
    .fifo_wr         (fifo_wr),
    .fifo_rd         (fifo_rd),
    .mbx_wr          (mbx_wr),
    .mbx_rd          (mbx_rd),
    .mail_out_q      (mail_out_q),
    .mail_out_full_n (mail_out_full_n)
);

// File: tb/tb_pctl_port.sv
module tb_pctl_port;
    localparam int unsigned DW = 36;
    localparam logic        WL = 1'b0;

    logic          clk = 1'b0;
    logic          rst;
    logic          cs_n, rw_sel, en, mb_sel, in_rdy, out_rdy, peer_mbx_rd;
    logic [DW-1:0] bus_in, fifo_q, mail_in_q;
    logic [DW-1:0] dout, fifo_wdata, mail_out_q;
    logic          dout_oe, fifo_wr, fifo_rd, mbx_wr, mbx_rd, mail_out_full_n;

    always #4 clk = ~clk;

    pctl_port #(.DATA_W(DW), .WR_LEVEL(WL)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rw_sel(rw_sel), .en(en), .mb_sel(mb_sel),
        .in_rdy(in_rdy), .out_rdy(out_rdy), .bus_in(bus_in), .fifo_q(fifo_q),
        .mail_in_q(mail_in_q), .peer_mbx_rd(peer_mbx_rd), .dout(dout), .dout_oe(dout_oe),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_rd(fifo_rd), .mbx_wr(mbx_wr),
        .mbx_rd(mbx_rd), .mail_out_q(mail_out_q), .mail_out_full_n(mail_out_full_n)
    );

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done  = 0;

    // reference model state
    logic          e_fwr, e_frd, e_mwr, e_mrd, e_full_n;
    logic [DW-1:0] e_wdata, e_mail;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic f_oe(logic c, logic r);
        return !c && (r != WL);
    endfunction

    function automatic logic [DW-1:0] f_dout(logic m, logic [DW-1:0] fq, logic [DW-1:0] mq);
        return m ? mq : fq;
    endfunction

    function automatic logic [DW-1:0] rnd_word();
        return {$urandom_range(15, 0), $urandom()};
    endfunction

    // advance the model across one rising edge using the present inputs
    task automatic model_edge();
        logic wgo, rgo, acc;
        wgo = !cs_n && (rw_sel == WL) && en;
        rgo = !cs_n && (rw_sel != WL) && en;
        if (rst) begin
            e_fwr = 0; e_frd = 0; e_mwr = 0; e_mrd = 0;
            e_full_n = 1; e_mail = '0; e_wdata = '0;
        end else begin
            acc   = wgo && mb_sel && e_full_n;
            e_fwr = wgo && !mb_sel && in_rdy;
            e_frd = rgo && !mb_sel && out_rdy;
            e_mwr = acc;
            e_mrd = rgo && mb_sel;
            if (e_fwr) e_wdata = bus_in;
            if (acc) begin
                e_mail   = bus_in;
                e_full_n = 0;
            end else if (peer_mbx_rd) begin
                e_full_n = 1;
            end
        end
    endtask

    // check registered outputs (called at negedge, after the edge)
    task automatic check_regs();
        chk("R2 fifo_wr",  fifo_wr, e_fwr);
        chk("R3 fifo_rd",  fifo_rd, e_frd);
        chk("R5 mbx_wr",   mbx_wr,  e_mwr);
        chk("R7 mbx_rd",   mbx_rd,  e_mrd);
        chk("R8 full_n",   mail_out_full_n, e_full_n);
        chk("R6 mail_q",   mail_out_q, e_mail);
        if (e_fwr) chk("R2 fifo_wdata", fifo_wdata, e_wdata);
    endtask

    task automatic check_comb();
        #1;
        chk("R1 dout_oe", dout_oe, f_oe(cs_n, rw_sel));
        if (dout_oe) chk("R4 dout", dout, f_dout(mb_sel, fifo_q, mail_in_q));
    endtask

    // one cycle: apply inputs at negedge, check combinational, cross edge, check regs
    task automatic step(input logic r, input logic c, input logic w, input logic e,
                        input logic m, input logic ir, input logic orr, input logic pr,
                        input logic [DW-1:0] d);
        rst = r; cs_n = c; rw_sel = w; en = e; mb_sel = m; in_rdy = ir; out_rdy = orr;
        peer_mbx_rd = pr; bus_in = d; fifo_q = rnd_word(); mail_in_q = rnd_word();
        check_comb();
        model_edge();
        @(negedge clk);
        check_regs();
    endtask

    initial begin
        void'($urandom(32'h5EED_0C01));
        rst = 1; cs_n = 1; rw_sel = 0; en = 0; mb_sel = 0; in_rdy = 0; out_rdy = 0;
        peer_mbx_rd = 0; bus_in = '0; fifo_q = '0; mail_in_q = '0;
        e_fwr = 0; e_frd = 0; e_mwr = 0; e_mrd = 0; e_full_n = 1; e_mail = '0; e_wdata = '0;
        @(negedge clk);
        // R10 reset state
        step(1, 0, WL, 1, 0, 1, 1, 0, rnd_word());
        step(1, 0, WL, 1, 1, 1, 1, 0, rnd_word());

        // R5 mail write while empty
        step(0, 0, WL, 1, 1, 1, 1, 0, 36'hA_5A5A_0001);
        // R6 second write while full ignored
        step(0, 0, WL, 1, 1, 1, 1, 0, 36'h3_0000_BEEF);
        // R8 full + write + release at same edge: write ignored, flag released
        step(0, 0, WL, 1, 1, 1, 1, 1, 36'h7_1111_2222);
        // empty + write + release at same edge: write wins
        step(0, 0, WL, 1, 1, 1, 1, 1, 36'h1_2345_6789);
        step(0, 1, WL, 1, 1, 1, 1, 1, '0);
        // R2 FIFO write, and blocked by in_rdy low
        step(0, 0, WL, 1, 0, 1, 0, 0, 36'hF_FFFF_FFFF);
        step(0, 0, WL, 1, 0, 0, 1, 0, 36'h0_0000_0001);
        // R3 FIFO read, and blocked by out_rdy low
        step(0, 0, !WL, 1, 0, 0, 1, 0, '0);
        step(0, 0, !WL, 1, 0, 1, 0, 0, '0);
        // R7 mailbox read; R4 with en low presenting mail
        step(0, 0, !WL, 1, 1, 0, 1, 0, '0);
        step(0, 0, !WL, 0, 1, 1, 1, 0, '0);
        // R9 enable low with every other control asserted
        step(0, 0, WL, 0, 0, 1, 1, 0, rnd_word());
        step(0, 0, WL, 0, 1, 1, 1, 0, rnd_word());

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            step(($urandom_range(99, 0) < 2),
                 ($urandom_range(99, 0) < 15),
                 $urandom_range(1, 0),
                 ($urandom_range(99, 0) < 70),
                 ($urandom_range(99, 0) < 40),
                 ($urandom_range(99, 0) < 75),
                 ($urandom_range(99, 0) < 75),
                 ($urandom_range(99, 0) < 25),
                 rnd_word());
        end

        // R10 reset clears a full mailbox
        step(0, 0, WL, 1, 1, 1, 1, 0, 36'h5_0000_0005);
        step(1, 0, WL, 1, 1, 1, 1, 0, 36'h6_0000_0006);
        step(0, 1, WL, 0, 0, 0, 0, 0, '0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule